// File: doc/BRIEF.md
# Coprocessor Periodic Restart Timer

This block sequences a small low-power coprocessor that runs one short program, halts, and is brought back to life again and again on a fixed schedule. Software starts the sequence with a run command that carries the program's start address. From then on, every time the coprocessor halts the block counts ticks of a slow clock. When the interval picked from one of five interval values has passed, plus a fixed overhead, the block pulses a restart that sends the coprocessor back to the latched start address.

The coprocessor program steers the block with two commands from its decoder. A select command picks which interval value is used. A wake command asks the main CPU to wake up, and it neither halts the program nor stops the schedule. A timer-enable bit gates every timed restart. Software can clear it, and so can a register write from the coprocessor. Once it is clear, the program that is running finishes normally and is not restarted until software issues a new run command.

Top module: `coproc_restart_timer`

## Requirements
- R1: After reset, restartPulse, wakePulse, wakeFlag, running and timerEn are 0 and activeSel is 0.
- R2: A swRun pulse latches swStartAddr into startAddr and sets timerEn. If the coprocessor is halted, it also sets running and raises restartPulse for exactly one cycle on the next clock. If the coprocessor is running, no restart pulse is issued.
- R3: A haltExec pulse while running clears running and the tick counter. While halted and enabled, every slowTick cycle advances the counter. restartPulse rises on the slowTick that completes interval+16 ticks since the halt, where interval is the value selected by activeSel, and running is set again.
- R4: A select command (cmdValid with cmdOpcode = 9 and cmdSubOp = 1) loads cmdCycleSel into activeSel when cmdCycleSel is 0 to 4, and loads 0 when it is 5 to 7. A command with any other opcode leaves activeSel unchanged.
- R5: A wake command (cmdValid with cmdOpcode = 9, cmdSubOp = 0 and cmdWakeBit = 1) gives a one-cycle wakePulse and sets wakeFlag, and leaves running, timerEn and the following periodic restarts unaffected. With cmdWakeBit = 0 it does nothing.
- R6: wakeAck clears wakeFlag. When a wake command and wakeAck arrive in the same cycle, the flag ends up set.
- R7: swTimerClr or cpTimerClr clears timerEn without stopping a running program. No timed restart follows until the next swRun. swRun takes priority over a clear in the same cycle.
- R8: While halted, decoder commands and further haltExec pulses are ignored: activeSel and wakeFlag keep their values, and the interval is still timed from the first halt.
- R9: No restart is issued while running, and the counter does not advance in cycles without slowTick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slowTick | input | 1 | One-cycle enable for each slow-clock period |
| haltExec | input | 1 | Coprocessor executed its halt instruction |
| cmdValid | input | 1 | Decoder command valid |
| cmdOpcode | input | 4 | Command major opcode |
| cmdSubOp | input | 3 | Command sub-opcode |
| cmdWakeBit | input | 1 | Wakeup flag field of the command |
| cmdCycleSel | input | 3 | Interval select field of the command |
| cpTimerClr | input | 1 | Coprocessor register write clearing the timer enable |
| swRun | input | 1 | Software run command |
| swStartAddr | input | ADDR_W | Start address carried by swRun |
| swTimerClr | input | 1 | Software clear of the timer enable |
| wakeAck | input | 1 | Software acknowledge of the wake flag |
| intervalBus | input | NUM_INTERVALS*CNT_W | Interval values, entry i at bits i*CNT_W upward |
| restartPulse | output | 1 | Restart the coprocessor at startAddr |
| startAddr | output | ADDR_W | Latched program start address |
| running | output | 1 | Coprocessor is considered running |
| timerEn | output | 1 | Timed restarts enabled |
| activeSel | output | 3 | Current interval select |
| wakePulse | output | 1 | One-cycle wake request to the main CPU |
| wakeFlag | output | 1 | Sticky wake request |

## Verification
The wake command and the software acknowledge can land on the same clock edge, and the flag must come out set. The bench drives both at one falling edge and checks wakeFlag after the next rising edge. A clear of the timer enable can also meet a software run in one cycle. The bench drives that pair together and judges it by a restart pulse on the next cycle and timerEn staying high. In a third case, a second halt while the coprocessor is already halted must not restart the interval: the bench checks that the total restart time is still measured from the first halt.

// File: rtl/coproc_timer_pkg.sv
package coproc_timer_pkg;
  localparam int SEL_W = 3;
  localparam logic [3:0] OP_CTRL  = 4'd9;
  localparam logic [2:0] SUB_WAKE = 3'd0;
  localparam logic [2:0] SUB_SEL  = 3'd1;

  typedef struct packed {
    logic cntClear;
    logic cntAdvance;
    logic latchAddr;
  } dpStrobes_t;
endpackage

// File: rtl/coproc_timer_ctrl.sv
module coproc_timer_ctrl
  import coproc_timer_pkg::*;
#(
  parameter int NUM_INTERVALS = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slowTick,
  input  logic             haltExec,
  input  logic             cmdValid,
  input  logic [3:0]       cmdOpcode,
  input  logic [2:0]       cmdSubOp,
  input  logic             cmdWakeBit,
  input  logic [SEL_W-1:0] cmdCycleSel,
  input  logic             cpTimerClr,
  input  logic             swRun,
  input  logic             swTimerClr,
  input  logic             wakeAck,
  input  logic             expire,
  output dpStrobes_t       strobes,
  output logic [SEL_W-1:0] selIdx,
  output logic             running,
  output logic             timerEn,
  output logic             restartPulse,
  output logic             wakePulse,
  output logic             wakeFlag
);
  localparam logic [SEL_W-1:0] SEL_LIMIT = SEL_W'(NUM_INTERVALS);

  logic isCtrlOp, selCmd, wakeCmd, haltEv, clrEv, fire, runFromHalt;
  logic [SEL_W-1:0] nextSel;

  always_comb begin
    isCtrlOp    = cmdValid && running && (cmdOpcode == OP_CTRL);
    selCmd      = isCtrlOp && (cmdSubOp == SUB_SEL);
    wakeCmd     = isCtrlOp && (cmdSubOp == SUB_WAKE) && cmdWakeBit;
    haltEv      = running && haltExec;
    clrEv       = swTimerClr || cpTimerClr;
    fire        = expire && !clrEv;
    runFromHalt = swRun && !running;
    nextSel     = (cmdCycleSel < SEL_LIMIT) ? cmdCycleSel : '0;
  end

  always_comb begin
    strobes.cntAdvance = !running && timerEn && slowTick && !swRun;
    strobes.cntClear   = haltEv || fire || swRun;
    strobes.latchAddr  = swRun;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running      <= 1'b0;
      timerEn      <= 1'b0;
      restartPulse <= 1'b0;
      wakePulse    <= 1'b0;
      wakeFlag     <= 1'b0;
      selIdx       <= '0;
    end else begin
      restartPulse <= runFromHalt || fire;
      if (runFromHalt || fire) running <= 1'b1;
      else if (haltEv)         running <= 1'b0;

      if (swRun)      timerEn <= 1'b1;
      else if (clrEv) timerEn <= 1'b0;

      wakePulse <= wakeCmd;
      if (wakeCmd)      wakeFlag <= 1'b1;
      else if (wakeAck) wakeFlag <= 1'b0;

      if (selCmd) selIdx <= nextSel;
    end
  end
endmodule

// File: rtl/coproc_timer_dp.sv
module coproc_timer_dp
  import coproc_timer_pkg::*;
#(
  parameter int NUM_INTERVALS = 5,
  parameter int CNT_W         = 16,
  parameter int ADDR_W        = 11,
  parameter int OVERHEAD      = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  dpStrobes_t                     strobes,
  input  logic [SEL_W-1:0]               selIdx,
  input  logic [NUM_INTERVALS*CNT_W-1:0] intervalBus,
  input  logic [ADDR_W-1:0]              swStartAddr,
  output logic [ADDR_W-1:0]              startAddr,
  output logic                           expire
);
  localparam int TGT_W = CNT_W + 1;
  localparam logic [TGT_W-1:0] OVH_V = TGT_W'(OVERHEAD);

  logic [CNT_W-1:0] intervals [NUM_INTERVALS];
  logic [CNT_W-1:0] selected;
  logic [TGT_W-1:0] target, tickCount;

  for (genvar gi = 0; gi < NUM_INTERVALS; gi++) begin : g_unpack
    assign intervals[gi] = intervalBus[gi*CNT_W +: CNT_W];
  end

  always_comb begin
    selected = intervals[0];
    for (int i = 1; i < NUM_INTERVALS; i++)
      if (selIdx == SEL_W'(i)) selected = intervals[i];
    target = {1'b0, selected} + OVH_V;
    expire = strobes.cntAdvance && (tickCount == target - TGT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tickCount <= '0;
      startAddr <= '0;
    end else begin
      if (strobes.cntClear)        tickCount <= '0;
      else if (strobes.cntAdvance) tickCount <= tickCount + TGT_W'(1);
      if (strobes.latchAddr) startAddr <= swStartAddr;
    end
  end
endmodule

// File: rtl/coproc_restart_timer.sv
module coproc_restart_timer
  import coproc_timer_pkg::*;
#(
  parameter int NUM_INTERVALS = 5,
  parameter int CNT_W         = 16,
  parameter int ADDR_W        = 11,
  parameter int OVERHEAD      = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           slowTick,
  input  logic                           haltExec,
  input  logic                           cmdValid,
  input  logic [3:0]                     cmdOpcode,
  input  logic [2:0]                     cmdSubOp,
  input  logic                           cmdWakeBit,
  input  logic [2:0]                     cmdCycleSel,
  input  logic                           cpTimerClr,
  input  logic                           swRun,
  input  logic [ADDR_W-1:0]              swStartAddr,
  input  logic                           swTimerClr,
  input  logic                           wakeAck,
  input  logic [NUM_INTERVALS*CNT_W-1:0] intervalBus,
  output logic                           restartPulse,
  output logic [ADDR_W-1:0]              startAddr,
  output logic                           running,
  output logic                           timerEn,
  output logic [2:0]                     activeSel,
  output logic                           wakePulse,
  output logic                           wakeFlag
);
  dpStrobes_t strobes;
  logic expire;

  coproc_timer_ctrl #(.NUM_INTERVALS(NUM_INTERVALS)) u_ctrl (
    .clk, .rst_n, .slowTick, .haltExec, .cmdValid, .cmdOpcode, .cmdSubOp,
    .cmdWakeBit, .cmdCycleSel, .cpTimerClr, .swRun, .swTimerClr, .wakeAck,
    .expire, .strobes, .selIdx(activeSel), .running, .timerEn,
    .restartPulse, .wakePulse, .wakeFlag
  );

  coproc_timer_dp #(
    .NUM_INTERVALS(NUM_INTERVALS), .CNT_W(CNT_W),
    .ADDR_W(ADDR_W), .OVERHEAD(OVERHEAD)
  ) u_dp (
    .clk, .rst_n, .strobes, .selIdx(activeSel), .intervalBus,
    .swStartAddr, .startAddr, .expire
  );
endmodule

// File: rtl/coproc_restart_timer_chk.sv
module coproc_restart_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       restartPulse,
  input logic       running,
  input logic       timerEn,
  input logic [2:0] activeSel,
  input logic       wakePulse,
  input logic       wakeFlag
);
  p_restart_from_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restartPulse |-> !$past(running));
  p_restart_sets_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    restartPulse |-> running);
  p_restart_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    restartPulse |=> !restartPulse);
  p_restart_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restartPulse |-> timerEn);
  p_wake_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wakePulse |-> wakeFlag);
  p_wake_while_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wakePulse |-> $past(running));
  p_sel_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    activeSel <= 3'd4);
endmodule

bind coproc_restart_timer coproc_restart_timer_chk u_chk (
  .clk, .rst_n, .restartPulse, .running, .timerEn, .activeSel,
  .wakePulse, .wakeFlag
);

// File: tb/tb_coproc_restart_timer.sv
module tb_coproc_restart_timer;
  localparam int CNT_W = 16;
  localparam int ADDR_W = 11;

  logic clk = 0, rst_n = 0;
  logic slowTick = 1, haltExec = 0, cmdValid = 0, cmdWakeBit = 0;
  logic [3:0] cmdOpcode = 0;
  logic [2:0] cmdSubOp = 0, cmdCycleSel = 0;
  logic cpTimerClr = 0, swRun = 0, swTimerClr = 0, wakeAck = 0;
  logic [ADDR_W-1:0] swStartAddr = 0;
  logic [5*CNT_W-1:0] intervalBus;
  logic restartPulse, running, timerEn, wakePulse, wakeFlag;
  logic [ADDR_W-1:0] startAddr;
  logic [2:0] activeSel;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  // interval values: 5, 0, 20, 3, 40
  assign intervalBus = {16'd40, 16'd3, 16'd20, 16'd0, 16'd5};

  always #10 clk = ~clk;

  coproc_restart_timer dut (.*);

  // {select code, expected activeSel, expected period}
  localparam logic [15:0] VECS [7] = '{
    {4'd2, 4'd2, 8'd36}, {4'd0, 4'd0, 8'd21}, {4'd1, 4'd1, 8'd16},
    {4'd3, 4'd3, 8'd19}, {4'd4, 4'd4, 8'd56}, {4'd5, 4'd0, 8'd21},
    {4'd7, 4'd0, 8'd21}};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sendCmd(input logic [3:0] op, input logic [2:0] sub,
                         input logic wb, input logic [2:0] sel);
    @(negedge clk);
    cmdValid = 1; cmdOpcode = op; cmdSubOp = sub; cmdWakeBit = wb; cmdCycleSel = sel;
    @(negedge clk);
    cmdValid = 0;
  endtask

  task automatic doRun(input logic [ADDR_W-1:0] a);
    @(negedge clk); swRun = 1; swStartAddr = a;
    @(negedge clk); swRun = 0;
  endtask

  task automatic pulseHalt();
    @(negedge clk); haltExec = 1;
    @(negedge clk); haltExec = 0;
  endtask

  task automatic waitRestart(input int limit, output int n);
    n = 0;
    while (!restartPulse && n < limit) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic quietWindow(input int len, output bit seen);
    seen = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (restartPulse) seen = 1;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int n;
    bit seen;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!restartPulse && !running && !timerEn && !wakePulse && !wakeFlag && activeSel == 0,
        "R1 reset", {running, timerEn, wakeFlag, activeSel}, 0);
    rst_n = 1;

    // R2 run from halted
    doRun(11'h02A);
    chk(restartPulse && running && timerEn, "R2 run pulse", {restartPulse, running, timerEn}, 7);
    chk(startAddr == 11'h02A, "R2 start address", startAddr, 11'h02A);
    @(negedge clk);
    chk(!restartPulse, "R2 single pulse", restartPulse, 0);

    // R3/R4 table of interval selections and periods
    for (int v = 0; v < 7; v++) begin
      sendCmd(4'd9, 3'd1, 0, VECS[v][14:12]);
      chk(activeSel == VECS[v][10:8], "R4 select", activeSel, VECS[v][10:8]);
      pulseHalt();
      chk(!running, "R3 halted", running, 0);
      waitRestart(200, n);
      chk(n == int'(VECS[v][7:0]), "R3 period", n, VECS[v][7:0]);
      chk(running && startAddr == 11'h02A, "R3 restart state", startAddr, 11'h02A);
    end

    // R4 other opcode ignored (select is 0 now)
    sendCmd(4'd8, 3'd1, 0, 3'd3);
    chk(activeSel == 0, "R4 other opcode", activeSel, 0);

    // R2 run while running: address latched, no pulse
    doRun(11'h055);
    chk(!restartPulse && startAddr == 11'h055, "R2 run while running", restartPulse, 0);
    pulseHalt();
    waitRestart(200, n);
    chk(n == 21 && startAddr == 11'h055, "R2 new address restart", n, 21);

    // R5 wake
    sendCmd(4'd9, 3'd0, 1, 3'd0);
    chk(wakePulse && wakeFlag && running && timerEn, "R5 wake", {wakePulse, wakeFlag, running, timerEn}, 15);
    @(negedge clk);
    chk(!wakePulse && wakeFlag, "R5 wake single/sticky", {wakePulse, wakeFlag}, 1);
    pulseHalt();
    waitRestart(200, n);
    chk(n == 21, "R5 restarts continue after wake", n, 21);

    // R6 ack, and ack colliding with wake
    @(negedge clk); wakeAck = 1;
    @(negedge clk); wakeAck = 0;
    chk(!wakeFlag, "R6 ack clears", wakeFlag, 0);
    @(negedge clk);
    cmdValid = 1; cmdOpcode = 4'd9; cmdSubOp = 3'd0; cmdWakeBit = 1; wakeAck = 1;
    @(negedge clk);
    cmdValid = 0; wakeAck = 0;
    chk(wakeFlag, "R6 set wins over ack", wakeFlag, 1);
    @(negedge clk); wakeAck = 1;
    @(negedge clk); wakeAck = 0;

    // R5 wake bit clear does nothing
    sendCmd(4'd9, 3'd0, 0, 3'd0);
    chk(!wakePulse && !wakeFlag, "R5 wake bit 0", {wakePulse, wakeFlag}, 0);

    // R7 coprocessor clear while running; R8 commands ignored while halted
    @(negedge clk); cpTimerClr = 1;
    @(negedge clk); cpTimerClr = 0;
    chk(running && !timerEn, "R7 clear keeps program", {running, timerEn}, 2);
    pulseHalt();
    sendCmd(4'd9, 3'd1, 0, 3'd4);
    chk(activeSel == 0, "R8 select ignored halted", activeSel, 0);
    sendCmd(4'd9, 3'd0, 1, 3'd0);
    chk(!wakeFlag, "R8 wake ignored halted", wakeFlag, 0);
    quietWindow(100, seen);
    chk(!seen && !running, "R7 no restart after clear", seen, 0);
    doRun(11'h055);
    chk(restartPulse && timerEn, "R7 run re-enables", {restartPulse, timerEn}, 3);

    // R7 software clear during halted count
    pulseHalt();
    repeat (5) @(negedge clk);
    swTimerClr = 1; @(negedge clk); swTimerClr = 0;
    quietWindow(60, seen);
    chk(!seen && !timerEn, "R7 sw clear mid-count", seen, 0);
    @(negedge clk); swRun = 1; swTimerClr = 1;
    @(negedge clk); swRun = 0; swTimerClr = 0;
    chk(restartPulse && timerEn, "R7 run wins over clear", {restartPulse, timerEn}, 3);

    // R9 no advance without slowTick
    @(negedge clk); slowTick = 0; haltExec = 1;
    @(negedge clk); haltExec = 0;
    quietWindow(60, seen);
    chk(!seen && !running, "R9 no tick no restart", seen, 0);
    slowTick = 1;
    waitRestart(200, n);
    chk(n == 21, "R9 ticks counted", n, 21);

    // R8 second halt while halted does not restart the interval
    pulseHalt();
    repeat (8) @(negedge clk);
    haltExec = 1; @(negedge clk); haltExec = 0;
    waitRestart(200, n);
    chk(n + 9 == 21, "R8 halt ignored halted", n + 9, 21);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule